// File: doc/BRIEF.md
# Glitch-Free System Clock Selector

This block produces the system clock of an audio-style subsystem from one of two free-running, mutually asynchronous clocks: a master clock from a pin and the output of an on-chip PLL. The master clock can first be inverted. A select input picks the source, and a handshake between two enable chains moves the output from the old clock to the new one without runt pulses.

A force input covers the case where the old clock has already stopped. The old source's enable is then cleared at once, so the new source can take over using only its own edges. After the mux, a pre-divider passes the chosen clock straight through or halves it, as set by a two-bit code. A status output reports which source is driving the output.

All control inputs are plain static levels. There is no data stream, so the block has no valid/ready interface.

Top module: `sysclk_sel_top`

## Requirements
- R1: While reset is low, the system clock output is low and the status output is 0. After reset is released, the master clock drives the output with the select input at 0.
- R2: Select 0 picks the master clock and select 1 picks the PLL clock. With both clocks running, the status output equals the select input (1 means PLL) no later than four falling edges of the old source plus four of the new source after a select change.
- R3: The two source enables are never high at the same time. With force at 0, no high or low pulse of the system clock is shorter than the half-period of the faster source.
- R4: With force at 1, a switch away from a stopped source completes: status follows the select and the output toggles at the new source's rate.
- R5: With force at 0 and the old source stopped, a select change does not complete: status keeps its old value and the output makes no rising edge.
- R6: Divider code 2'b00 gives the selected clock's period. Code 2'b10 gives exactly twice that period.
- R7: The reserved divider codes 2'b01 and 2'b11 act like 2'b00 (no division).
- R8: With invert at 1, the master clock is inverted before selection. While the master clock drives the output with no division, the output equals the master clock XOR the invert bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock |
| pllclk_i | input | 1 | PLL output clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 1 | Source select: 0 master, 1 PLL |
| force_i | input | 1 | Let a switch complete when the old source has stopped |
| div_code_i | input | 2 | Pre-divider code: 00 divide by 1, 10 divide by 2, others divide by 1 |
| mclk_inv_i | input | 1 | Invert the master clock before selection |
| sysclk_o | output | 1 | System clock |
| src_is_pll_o | output | 1 | 1 when the PLL clock drives the output |

## Verification
The bench sweeps every divider code and both invert settings. For each setting it switches the source in both directions, measures every output pulse during the switches, and checks the steady-state period against the source period times the division factor. A design that enabled the new source before the old one had let go, or that gated on the wrong edge, would produce a runt pulse that the width monitor catches. A design that decoded a reserved code as a division would show a doubled period. The bench then stops the PLL while it drives the output. It checks that a select change without force leaves the output frozen and the status unchanged; a mux that skipped the handshake would switch anyway. It then checks that force lets the master clock take over; a mux that waited on the stopped clock would hang there.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int NUM_SRC    = 2;
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    DIV_PASS  = 2'b00,
    DIV_RSV_A = 2'b01,
    DIV_HALF  = 2'b10,
    DIV_RSV_B = 2'b11
  } div_code_e;

  // Only the half code divides; reserved codes fall back to pass-through.
  function automatic logic code_halves(input logic [1:0] code);
    return code == DIV_HALF;
  endfunction
endpackage

// File: rtl/clk_src_cond.sv
module clk_src_cond (
  input  logic clk_i,
  input  logic inv_i,
  output logic clk_o
);
  assign clk_o = clk_i ^ inv_i;
endmodule

// File: rtl/clk_enable_chain.sv
module clk_enable_chain #(
  parameter int DEPTH = sysclk_pkg::SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic clr_i,
  input  logic req_i,
  output logic en_o
);
  localparam int TOP = DEPTH - 1;

  logic [TOP:0] stage_q;

  // Falling-edge stages, so the enable never moves while the source is high.
  always_ff @(negedge clk_i or posedge clr_i) begin
    if (clr_i) stage_q <= '0;
    else       stage_q <= {stage_q[TOP-1:0], req_i};
  end

  assign en_o = stage_q[TOP];
endmodule

// File: rtl/gf_clk_mux.sv
module gf_clk_mux #(
  parameter int N = sysclk_pkg::NUM_SRC
) (
  input  logic [N-1:0] src_clk_i,
  input  logic         rst_ni,
  input  logic         sel_i,
  input  logic         force_i,
  output logic [N-1:0] en_o,
  output logic         gclk_o
);
  logic en_q [N];

  for (genvar g = 0; g < N; g++) begin : g_src
    logic other_en;
    logic mine;
    logic req;
    logic clr;
    assign other_en = (g == 0) ? en_q[1] : en_q[0];
    assign mine     = (sel_i == 1'(g));
    assign req      = mine & ~other_en;
    // Force drops a deselected source at once, without waiting for its edges.
    assign clr      = ~rst_ni | (force_i & ~mine);

    clk_enable_chain u_chain (
      .clk_i (src_clk_i[g]),
      .clr_i (clr),
      .req_i (req),
      .en_o  (en_q[g])
    );
    assign en_o[g] = en_q[g];
  end

  assign gclk_o = |(src_clk_i & en_o);
endmodule

// File: rtl/clk_prediv.sv
module clk_prediv (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] div_code_i,
  output logic       clk_o
);
  logic half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else         half_q <= ~half_q;
  end

  assign clk_o = sysclk_pkg::code_halves(div_code_i) ? half_q : clk_i;
endmodule

// File: rtl/sysclk_sel_top.sv
module sysclk_sel_top (
  input  logic       mclk_i,
  input  logic       pllclk_i,
  input  logic       rst_ni,
  input  logic       src_sel_i,
  input  logic       force_i,
  input  logic [1:0] div_code_i,
  input  logic       mclk_inv_i,
  output logic       sysclk_o,
  output logic       src_is_pll_o
);
  logic       mclk_c;
  logic       gclk;
  logic [1:0] en_vec;
  logic       en_m;
  logic       en_p;

  clk_src_cond u_cond (
    .clk_i (mclk_i),
    .inv_i (mclk_inv_i),
    .clk_o (mclk_c)
  );

  gf_clk_mux #(.N(sysclk_pkg::NUM_SRC)) u_mux (
    .src_clk_i ({pllclk_i, mclk_c}),
    .rst_ni    (rst_ni),
    .sel_i     (src_sel_i),
    .force_i   (force_i),
    .en_o      (en_vec),
    .gclk_o    (gclk)
  );

  assign en_m = en_vec[0];
  assign en_p = en_vec[1];

  clk_prediv u_div (
    .clk_i      (gclk),
    .rst_ni     (rst_ni),
    .div_code_i (div_code_i),
    .clk_o      (sysclk_o)
  );

  // The PLL enable lives in the PLL domain, so the flag is already in that domain.
  assign src_is_pll_o = en_p;
endmodule

// File: rtl/sysclk_sel_chk.sv
module sysclk_sel_chk (
  input logic       mclk_i,
  input logic       pllclk_i,
  input logic       rst_ni,
  input logic       src_sel_i,
  input logic       force_i,
  input logic       mclk_inv_i,
  input logic [1:0] div_code_i,
  input logic       sysclk_o,
  input logic       en_m,
  input logic       en_p
);
  always @(posedge mclk_i) begin
    if (!rst_ni) AST_RESET_LOW: assert (!sysclk_o && !en_m && !en_p); // R1
  end

  AST_ONE_SOURCE_M: assert property (@(posedge mclk_i) disable iff (!rst_ni) !(en_m && en_p)); // R3
  AST_ONE_SOURCE_P: assert property (@(posedge pllclk_i) disable iff (!rst_ni) !(en_m && en_p)); // R3
  AST_FORCE_DROPS_PLL: assert property (@(posedge mclk_i) disable iff (!rst_ni) (force_i && !src_sel_i) |-> !en_p); // R4
  AST_FORCE_DROPS_MCLK: assert property (@(posedge pllclk_i) disable iff (!rst_ni) (force_i && src_sel_i) |-> !en_m); // R4
  AST_PASS_FOLLOWS_MCLK: assert property (@(posedge pllclk_i) disable iff (!rst_ni)
    (en_m && div_code_i != 2'b10) |-> (sysclk_o == (mclk_i ^ mclk_inv_i))); // R8
endmodule

bind sysclk_sel_top sysclk_sel_chk u_chk (
  .mclk_i     (mclk_i),
  .pllclk_i   (pllclk_i),
  .rst_ni     (rst_ni),
  .src_sel_i  (src_sel_i),
  .force_i    (force_i),
  .mclk_inv_i (mclk_inv_i),
  .div_code_i (div_code_i),
  .sysclk_o   (sysclk_o),
  .en_m       (en_m),
  .en_p       (en_p)
);

// File: tb/sysclk_sel_top_tb_top.sv
`timescale 1ns/100ps
module sysclk_sel_top_tb_top;
  localparam real M_PER = 20.0;
  localparam real P_PER = 14.0;
  localparam real MIN_W = 7.0;

  logic tb_clk = 1'b0, mclk = 1'b0, pllclk = 1'b0, pll_run = 1'b1;
  logic rst_n = 1'b0, sel = 1'b0, frc = 1'b0, inv = 1'b0;
  logic [1:0] code = 2'b00;
  logic sysclk, stat;

  always #2 tb_clk = ~tb_clk;
  always #10 mclk = ~mclk;
  always #7 pllclk = pll_run ? ~pllclk : 1'b0;

  sysclk_sel_top dut_i (
    .mclk_i(mclk), .pllclk_i(pllclk), .rst_ni(rst_n), .src_sel_i(sel),
    .force_i(frc), .div_code_i(code), .mclk_inv_i(inv),
    .sysclk_o(sysclk), .src_is_pll_o(stat)
  );

  int n_chk = 0, n_fail = 0, edges = 0, pulses = 0, shorts = 0;
  bit meas_en = 1'b0, prev_ok = 1'b0;
  realtime last_edge = 0.0;
  real min_w = 1.0e9;

  always @(posedge sysclk) edges++;

  // Pulse width monitor for R3
  always @(sysclk) begin
    if (meas_en && prev_ok) begin
      real w;
      w = $realtime - last_edge;
      pulses++;
      if (w < min_w) min_w = w;
      if (w < MIN_W - 0.05) shorts++;
    end
    last_edge = $realtime;
    prev_ok = meas_en;
  end

  task automatic check(input bit ok, input string req, input string what, input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge tb_clk);
    #0.5;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge tb_clk);
  endtask

  task automatic period(output real p);
    realtime t0;
    @(posedge sysclk);
    t0 = $realtime;
    @(posedge sysclk);
    p = $realtime - t0;
  endtask

  initial begin
    repeat (150000) @(posedge tb_clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    real p, exp_p;
    int e0;
    wait_cyc(5);
    check(sysclk == 1'b0, "R1", "output in reset", real'(sysclk), 0.0);
    check(stat == 1'b0, "R1", "status in reset", real'(stat), 0.0);
    step();
    rst_n = 1'b1;
    wait_cyc(100);
    check(stat == 1'b0, "R1", "status after reset", real'(stat), 0.0);
    period(p);
    check(p > M_PER - 0.05 && p < M_PER + 0.05, "R1", "period after reset", p, M_PER);

    // Sweep: invert x divider code x both switch directions
    for (int iv = 0; iv < 2; iv++) begin
      for (int cd = 0; cd < 4; cd++) begin
        meas_en = 1'b0;
        step();
        inv = iv[0];
        code = cd[1:0];
        wait_cyc(30);
        meas_en = 1'b1;
        for (int s = 0; s < 2; s++) begin
          step();
          sel = (s == 0);
          wait_cyc(100);
          check(stat == sel, "R2", "status after switch", real'(stat), real'(sel));
          period(p);
          exp_p = (sel ? P_PER : M_PER) * ((cd == 2) ? 2.0 : 1.0);
          if (cd == 2)
            check(p > exp_p - 0.05 && p < exp_p + 0.05, "R6", "halved period", p, exp_p);
          else if (cd[0])
            check(p > exp_p - 0.05 && p < exp_p + 0.05, "R7", "reserved code period", p, exp_p);
          else
            check(p > exp_p - 0.05 && p < exp_p + 0.05, "R2", "pass period", p, exp_p);
        end
        if (cd == 0) begin
          @(posedge mclk);
          #3;
          check(sysclk == (1'b1 ^ inv), "R8", "output while master high", real'(sysclk), real'(1'b1 ^ inv));
          @(negedge mclk);
          #3;
          check(sysclk == (1'b0 ^ inv), "R8", "output while master low", real'(sysclk), real'(1'b0 ^ inv));
        end
      end
    end
    check(shorts == 0 && pulses > 100, "R3", "shortest pulse during switches", min_w, MIN_W);

    // Stopped old source
    meas_en = 1'b0;
    step();
    inv = 1'b0;
    code = 2'b00;
    sel = 1'b1;
    wait_cyc(100);
    pll_run = 1'b0;
    wait_cyc(10);
    step();
    sel = 1'b0;
    e0 = edges;
    wait_cyc(100);
    check(stat == 1'b1, "R5", "status held without force", real'(stat), 1.0);
    check(edges == e0, "R5", "rising edges without force", real'(edges - e0), 0.0);
    step();
    frc = 1'b1;
    wait_cyc(50);
    check(stat == 1'b0, "R4", "status with force", real'(stat), 0.0);
    period(p);
    check(p > M_PER - 0.05 && p < M_PER + 0.05, "R4", "period with force", p, M_PER);
    step();
    frc = 1'b0;
    pll_run = 1'b1;
    wait_cyc(20);
    step();
    sel = 1'b1;
    wait_cyc(100);
    check(stat == 1'b1, "R2", "status after restart", real'(stat), 1.0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule